// File: doc/BRIEF.md
# LIN Frame Error Monitor

This block sits beside the frame sequencer of a LIN master node and watches its traffic for protocol and physical-layer faults. The local UART receiver hears every byte the node sends. The monitor compares each echoed byte with the byte that was sent. It also times the slave's response against a programmable whole-frame cycle budget. It watches the raw receive line for a level that does not move, and for a low level held past a character time.

A frame on the bus runs break, sync, identifier, one or more data bytes, then checksum. The timeout window opens when the identifier byte has gone out on a frame whose data comes from a slave. It closes when the checksum-received strobe arrives. A readback mismatch, an expired slave response or a stuck line produces a one-cycle abort pulse, which sends the frame sequencer back to idle. Every fault also sets a sticky flag, which software clears by writing a one to the matching clear input.

Top module: `lin_fault_watch`

## Requirements
- R1: When `rx_valid` arrives while a sent byte is awaiting readback and `rx_byte` differs from that byte, `bit_err` is set after that clock edge and `abort` is high for the following cycle only.
- R2: A readback equal to the sent byte sets no flag. A received byte with no sent byte awaiting readback is slave data and is never compared. Each sent byte is compared at most once.
- R3: With `to_limit` = N > 0, a strobe of `tx_valid` with `tx_is_id` = 1 and `slave_resp` = 1 starts the timer. If no `csum_done` arrives, `sto_flag` is set exactly N clock cycles after the start edge. In that same cycle `sto_irq` and `abort` are each high for one cycle.
- R4: A `csum_done` strobe that arrives before expiry, at the latest on the expiry edge itself, cancels the timeout. An identifier sent with `slave_resp` = 0 never starts the timer. `to_limit` = 0 disables the timeout.
- R5: While `frame_active` is high, `STUCK_BITS` (default 15) `bit_tick` pulses with no change on `rxd` set `pbe_flag`, and `abort` pulses. The flag appears after the edge that samples the last of those ticks.
- R6: Any change of `rxd` restarts the stuck-line count. While `frame_active` is low the count is held at zero, and `pbe_flag` is never set.
- R7: When `rxd` is low for `LOW_BITS` (default 10) consecutive `bit_tick` pulses, `fe_flag` is set whatever the state of `frame_active`, and no abort is produced.
- R8: Each flag stays set until its own clear input (`clr_bit`, `clr_sto`, `clr_pbe`, `clr_fe`) is high at a clock edge. A clear has no effect on the other flags. When a set and a clear of the same flag meet on one edge, the set wins.
- R9: After reset all flags, `sto_irq` and `abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Strobe: `tx_byte` has been handed to the transmitter |
| tx_byte | input | 8 | Byte being sent |
| tx_is_id | input | 1 | Qualifies `tx_valid`: the byte is the identifier |
| slave_resp | input | 1 | The current frame's data is supplied by a slave |
| rx_valid | input | 1 | Strobe: `rx_byte` received by the local UART |
| rx_byte | input | 8 | Received byte |
| rxd | input | 1 | Raw receive line, synchronous to `clk` |
| bit_tick | input | 1 | One pulse per bit time |
| frame_active | input | 1 | A frame transmission is in progress |
| csum_done | input | 1 | Strobe: checksum byte received, frame complete |
| to_limit | input | TO_W | Slave-timeout budget in clock cycles, 0 = off |
| clr_bit | input | 1 | Write-one-to-clear for `bit_err` |
| clr_sto | input | 1 | Write-one-to-clear for `sto_flag` |
| clr_pbe | input | 1 | Write-one-to-clear for `pbe_flag` |
| clr_fe | input | 1 | Write-one-to-clear for `fe_flag` |
| bit_err | output | 1 | Sticky readback mismatch flag |
| sto_flag | output | 1 | Sticky slave-timeout flag |
| sto_irq | output | 1 | One-cycle slave-timeout interrupt pulse |
| pbe_flag | output | 1 | Sticky stuck-line flag |
| fe_flag | output | 1 | Sticky framing-error (line held low) flag |
| abort | output | 1 | One-cycle pulse that returns the frame sequencer to idle |

## Verification
Every result is registered once at the top, so a fault detected from inputs sampled on edge E shows on the flags, `sto_irq` and `abort` just after E. The bench drives inputs on the falling edge and samples one falling edge later. The timeout is counted in edges from the identifier strobe: the flag must still be low after edge N-1 and high after edge N. For the two line checks the bench counts `bit_tick` pulses. It checks the flag is clear after one tick fewer than the limit and set after the last tick. It then checks that `abort` has dropped one cycle later.

// File: rtl/lin_fault_pkg.sv
package lin_fault_pkg;

  // Readback comparison: true when the echoed byte differs from the sent one.
  function automatic logic byte_differs(input logic [7:0] sent, input logic [7:0] heard);
    return (sent ^ heard) != 8'h00;
  endfunction

  // Timer expiry: cnt holds edges elapsed since start minus one; zero limit means off.
  function automatic logic budget_spent(input int unsigned cnt, input int unsigned lim);
    return (lim != 0) && (cnt + 1 == lim);
  endfunction

  // Run counter: the tick that completes the run.
  function automatic logic run_complete(input int unsigned cnt, input int unsigned lim);
    return cnt + 1 >= lim;
  endfunction

endpackage

// File: rtl/lin_readback_cmp.sv
module lin_readback_cmp
  import lin_fault_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic [7:0] tx_byte,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       mismatch
);
  logic       pending;
  logic [7:0] sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      sent_q  <= 8'h00;
    end else if (tx_valid) begin
      pending <= 1'b1;
      sent_q  <= tx_byte;
    end else if (rx_valid) begin
      pending <= 1'b0;
    end
  end

  assign mismatch = rx_valid && pending && byte_differs(sent_q, rx_byte);

  AST_COMPARE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !tx_valid) |=> !pending); // R2
endmodule

// File: rtl/lin_resp_timer.sv
module lin_resp_timer
  import lin_fault_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);
  logic            running;
  logic [TO_W-1:0] cnt;

  assign expire = running && !start && !stop &&
                  budget_spent(32'(cnt), 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      if (stop || expire) running <= 1'b0;
      else                cnt     <= cnt + 1'b1;
    end
  end

  AST_TIMER_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !running); // R4
endmodule

// File: rtl/lin_run_counter.sv
module lin_run_counter
  import lin_fault_pkg::*;
#(
  parameter int LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic tick,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          done;

  assign fire = en && !restart && tick && !done && run_complete(32'(cnt), 32'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!en || restart) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (tick && !done) begin
      if (fire) done <= 1'b1;
      else      cnt  <= cnt + 1'b1;
    end
  end

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < LIMIT); // R5
  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0)); // R6
endmodule

// File: rtl/lin_fault_watch.sv
module lin_fault_watch #(
  parameter int TO_W       = 16,
  parameter int STUCK_BITS = 15,
  parameter int LOW_BITS   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_valid,
  input  logic [7:0]      tx_byte,
  input  logic            tx_is_id,
  input  logic            slave_resp,
  input  logic            rx_valid,
  input  logic [7:0]      rx_byte,
  input  logic            rxd,
  input  logic            bit_tick,
  input  logic            frame_active,
  input  logic            csum_done,
  input  logic [TO_W-1:0] to_limit,
  input  logic            clr_bit,
  input  logic            clr_sto,
  input  logic            clr_pbe,
  input  logic            clr_fe,
  output logic            bit_err,
  output logic            sto_flag,
  output logic            sto_irq,
  output logic            pbe_flag,
  output logic            fe_flag,
  output logic            abort
);
  // Named internal events
  logic ev_bit, ev_sto, ev_pbe, ev_fe;
  logic rxd_q, rxd_edge, timer_start;

  assign rxd_edge    = rxd ^ rxd_q;
  assign timer_start = tx_valid && tx_is_id && slave_resp;

  lin_readback_cmp u_cmp (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .mismatch(ev_bit)
  );

  lin_resp_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(timer_start), .stop(csum_done),
    .limit(to_limit), .expire(ev_sto)
  );

  lin_run_counter #(.LIMIT(STUCK_BITS)) u_stuck (
    .clk(clk), .rst_n(rst_n),
    .en(frame_active), .restart(rxd_edge),
    .tick(bit_tick), .fire(ev_pbe)
  );

  lin_run_counter #(.LIMIT(LOW_BITS)) u_low (
    .clk(clk), .rst_n(rst_n),
    .en(1'b1), .restart(rxd),
    .tick(bit_tick), .fire(ev_fe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q    <= 1'b1;
      bit_err  <= 1'b0;
      sto_flag <= 1'b0;
      sto_irq  <= 1'b0;
      pbe_flag <= 1'b0;
      fe_flag  <= 1'b0;
      abort    <= 1'b0;
    end else begin
      rxd_q    <= rxd;
      bit_err  <= ev_bit | (bit_err  & ~clr_bit);
      sto_flag <= ev_sto | (sto_flag & ~clr_sto);
      pbe_flag <= ev_pbe | (pbe_flag & ~clr_pbe);
      fe_flag  <= ev_fe  | (fe_flag  & ~clr_fe);
      sto_irq  <= ev_sto;
      abort    <= ev_bit | ev_sto | ev_pbe;
    end
  end

  AST_BIT_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_err) |-> $past(rx_valid)); // R1
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sto_irq |-> sto_flag); // R3
  AST_PBE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pbe_flag) |-> $past(frame_active)); // R6
  AST_FE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_flag) |-> $past(!rxd)); // R7
  AST_STICKY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_err) |-> $past(clr_bit)); // R8
  AST_STICKY_PBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pbe_flag) |-> $past(clr_pbe)); // R8
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (bit_err || sto_flag || pbe_flag)); // R9
endmodule

// File: tb/lin_fault_watch_test.sv
module lin_fault_watch_test;
  localparam int TO_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_valid, tx_is_id, slave_resp, rx_valid, rxd, bit_tick;
  logic frame_active, csum_done, clr_bit, clr_sto, clr_pbe, clr_fe;
  logic [7:0] tx_byte, rx_byte;
  logic [TO_W-1:0] to_limit;
  logic bit_err, sto_flag, sto_irq, pbe_flag, fe_flag, abort;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lin_fault_watch #(.TO_W(TO_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_is_id(tx_is_id),
    .slave_resp(slave_resp), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rxd(rxd), .bit_tick(bit_tick), .frame_active(frame_active),
    .csum_done(csum_done), .to_limit(to_limit),
    .clr_bit(clr_bit), .clr_sto(clr_sto), .clr_pbe(clr_pbe), .clr_fe(clr_fe),
    .bit_err(bit_err), .sto_flag(sto_flag), .sto_irq(sto_irq),
    .pbe_flag(pbe_flag), .fe_flag(fe_flag), .abort(abort)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    tx_valid = 0; tx_byte = 0; tx_is_id = 0; slave_resp = 0;
    rx_valid = 0; rx_byte = 0; rxd = 1; bit_tick = 0;
    frame_active = 0; csum_done = 0; to_limit = 0;
    clr_bit = 0; clr_sto = 0; clr_pbe = 0; clr_fe = 0;
    rst_n = 0;
    step(2);
    rst_n = 1;
    step();
  endtask

  task automatic send(input logic [7:0] b, input logic id);
    tx_valid = 1; tx_byte = b; tx_is_id = id;
    step();
    tx_valid = 0; tx_is_id = 0;
  endtask

  task automatic hear(input logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    step();
    rx_valid = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; step(); bit_tick = 0; step();
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R9", "bit_err",  bit_err,  0);
    check("R9", "sto_flag", sto_flag, 0);
    check("R9", "sto_irq",  sto_irq,  0);
    check("R9", "pbe_flag", pbe_flag, 0);
    check("R9", "fe_flag",  fe_flag,  0);
    check("R9", "abort",    abort,    0);
  endtask

  task automatic t_readback();
    do_reset();
    send(8'h55, 0); hear(8'h55);
    check("R2", "match bit_err", bit_err, 0);
    hear(8'h12);
    check("R2", "slave data bit_err", bit_err, 0);
    send(8'hA5, 0); hear(8'hA4);
    check("R1", "mismatch bit_err", bit_err, 1);
    check("R1", "mismatch abort", abort, 1);
    step();
    check("R1", "abort one cycle", abort, 0);
    check("R1", "bit_err sticky", bit_err, 1);
  endtask

  task automatic t_timeout();
    do_reset();
    to_limit = 16'd7; slave_resp = 1;
    send(8'h3C, 1);
    step(6);
    check("R3", "flag low at N-1", sto_flag, 0);
    step();
    check("R3", "flag at N", sto_flag, 1);
    check("R3", "irq at N", sto_irq, 1);
    check("R3", "abort at N", abort, 1);
    step();
    check("R3", "irq one cycle", sto_irq, 0);
    check("R3", "abort one cycle", abort, 0);
  endtask

  task automatic t_cancel();
    do_reset();
    to_limit = 16'd8; slave_resp = 1;
    send(8'h3C, 1);
    step(4);
    csum_done = 1; step(); csum_done = 0;
    step(12);
    check("R4", "csum cancels", sto_flag, 0);
    do_reset();
    to_limit = 16'd5; slave_resp = 0;
    send(8'h3C, 1);
    step(10);
    check("R4", "master frame no timer", sto_flag, 0);
    do_reset();
    to_limit = 16'd0; slave_resp = 1;
    send(8'h3C, 1);
    step(40);
    check("R4", "limit zero off", sto_flag, 0);
  endtask

  task automatic t_stuck();
    do_reset();
    frame_active = 1; rxd = 1;
    ticks(14);
    check("R5", "pbe before limit", pbe_flag, 0);
    bit_tick = 1; step(); bit_tick = 0;
    check("R5", "pbe at limit", pbe_flag, 1);
    check("R5", "pbe abort", abort, 1);
    step();
    check("R5", "abort one cycle", abort, 0);
  endtask

  task automatic t_restart();
    do_reset();
    frame_active = 1; rxd = 1;
    ticks(10);
    rxd = 0; step(); rxd = 1; step();
    ticks(14);
    check("R6", "edge restarted count", pbe_flag, 0);
    ticks(1);
    check("R6", "full run after edge", pbe_flag, 1);
    do_reset();
    frame_active = 0; rxd = 1;
    ticks(20);
    check("R6", "idle frame no pbe", pbe_flag, 0);
  endtask

  task automatic t_low();
    do_reset();
    frame_active = 0; rxd = 0;
    ticks(9);
    check("R7", "fe before limit", fe_flag, 0);
    bit_tick = 1; step(); bit_tick = 0;
    check("R7", "fe at limit", fe_flag, 1);
    check("R7", "fe no abort", abort, 0);
    rxd = 1; step();
    check("R7", "fe no pbe", pbe_flag, 0);
  endtask

  task automatic t_clear();
    do_reset();
    send(8'h01, 0); hear(8'h02);
    frame_active = 1; ticks(15); frame_active = 0;
    check("R8", "both set", bit_err & pbe_flag, 1);
    clr_bit = 1; step(); clr_bit = 0;
    check("R8", "bit cleared", bit_err, 0);
    check("R8", "pbe untouched", pbe_flag, 1);
    clr_pbe = 1; step(); clr_pbe = 0;
    check("R8", "pbe cleared", pbe_flag, 0);
    send(8'h01, 0);
    rx_valid = 1; rx_byte = 8'h03; clr_bit = 1;
    step();
    rx_valid = 0; clr_bit = 0;
    check("R8", "set wins over clear", bit_err, 1);
  endtask

  initial begin
    t_reset();
    t_readback();
    t_timeout();
    t_cancel();
    t_stuck();
    t_restart();
    t_low();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule